// File: doc/BRIEF.md
# Frame alignment error counter

This block keeps a running tally of framing errors for a receive framer whose frames repeat every 125 µs and begin with a two-byte alignment word. Once per frame the framer presents both received alignment bytes with a valid strobe. Separately, it sends a single-cycle pulse each time an out-of-frame event is detected. A 2-bit mode input selects what is tallied:

- out-of-frame events;
- individual bit errors across the alignment word;
- whole-word errors;
- per-byte errors.

The tally is a saturating counter. A host reads it by pulsing a snapshot input. That pulse moves the live count into a holding register and restarts the live count, and no event that arrives in the same cycle is lost. Frame searching and out-of-frame detection are done elsewhere. This block acts only on the bytes and pulses it is given.

The alignment bytes arrive as a valid/ready stream. The block never applies back-pressure: `fa_ready` is high at all times. A transfer therefore happens on every cycle in which `fa_valid` is high. The remaining pins are plain control and status signals.

Top module: `frame_err_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `err_count` and `held_count` are both 0.
- R2: With mode 2'b00, each cycle with `oof_pulse` high adds exactly 1 to the count, whatever the value of `in_frame`. Alignment bytes have no effect on the count in this mode.
- R3: With mode 2'b01, each accepted frame adds the number of bit positions in which the first byte differs from 8'hF6, plus the number in which the second byte differs from 8'h28. This is at most 16 per frame.
- R4: With mode 2'b10, an accepted frame adds 1 if either byte differs from its expected value (8'hF6 and 8'h28), and 0 otherwise.
- R5: With mode 2'b11, an accepted frame adds 1 for each of the two bytes that differs from its expected value, so 0, 1 or 2 per frame.
- R6: Alignment bytes are counted only in a cycle with both `fa_valid` and `in_frame` high. In modes 2'b01, 2'b10 and 2'b11, `oof_pulse` has no effect on the count.
- R7: The 16-bit count saturates at 16'hFFFF. It never wraps to a smaller value except through a snapshot.
- R8: A cycle with `snap` high copies the live count into `held_count`. In that same cycle the live count restarts from that cycle's increment. At all other times `held_count` keeps its value.
- R9: `fa_ready` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fa_valid | input | 1 | Frame strobe: both alignment bytes are present this cycle |
| fa_ready | output | 1 | Always 1; the block never stalls the byte stream |
| fa1_i | input | 8 | First received alignment byte |
| fa2_i | input | 8 | Second received alignment byte |
| in_frame | input | 1 | High while the framer is aligned |
| oof_pulse | input | 1 | One-cycle pulse for each out-of-frame event |
| mode | input | 2 | Counting mode: 00 out-of-frame events, 01 bit errors, 10 word errors, 11 byte errors |
| snap | input | 1 | Host snapshot: latch the count into the holding register and clear the live count |
| err_count | output | 16 | Live saturating error count |
| held_count | output | 16 | Count captured by the last snapshot |

## Verification
On every cycle, the assertions bound the increment for each mode. They also check that nothing is added outside an accepted in-frame byte transfer or an out-of-frame pulse in the matching mode. Further assertions check that a saturated count stays at its ceiling, that the count never decreases between snapshots, and that a snapshot moves the old count into the holding register while keeping that cycle's increment. Only the bench's scenarios can show that the increments are correct for particular byte patterns. These include a single flipped bit, all sixteen bits flipped, and only one byte wrong. The same applies to reaching the ceiling after thousands of frames and to the exact value of the holding register when it is read.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [1:0] {
    MODE_OOF   = 2'b00,
    MODE_BITS  = 2'b01,
    MODE_WORD  = 2'b10,
    MODE_BYTES = 2'b11
  } fec_mode_e;

  localparam int FEC_BYTES = 2;
endpackage

// File: rtl/fec_popcount.sv
module fec_popcount #(
  parameter int W = 8
) (
  input  logic [W-1:0]           bits,
  output logic [$clog2(W+1)-1:0] ones
);
  localparam int OW = $clog2(W + 1);

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + OW'(bits[i]);
  end
endmodule

// File: rtl/fec_increment.sv
module fec_increment
  import fec_pkg::*;
#(
  parameter int              BYTE_W = 8,
  parameter logic [BYTE_W-1:0] EXP1 = 8'hF6,
  parameter logic [BYTE_W-1:0] EXP2 = 8'h28,
  parameter int              IW     = $clog2(2 * BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fec_mode_e         mode,
  input  logic              take,
  input  logic [BYTE_W-1:0] fa1,
  input  logic [BYTE_W-1:0] fa2,
  input  logic              oof,
  output logic [IW-1:0]     inc
);
  localparam int PW = $clog2(BYTE_W + 1);

  logic [FEC_BYTES-1:0][BYTE_W-1:0] rx_w, exp_w, diff_w;
  logic [FEC_BYTES-1:0][PW-1:0]     flips;
  logic [FEC_BYTES-1:0]             bad;

  assign rx_w  = {fa2, fa1};
  assign exp_w = {EXP2, EXP1};

  for (genvar b = 0; b < FEC_BYTES; b++) begin : g_byte
    assign diff_w[b] = rx_w[b] ^ exp_w[b];
    assign bad[b]    = |diff_w[b];
    fec_popcount #(.W(BYTE_W)) i_pc (.bits(diff_w[b]), .ones(flips[b]));
  end

  always_comb begin
    inc = '0;
    unique case (mode)
      MODE_OOF:   inc = IW'(oof);
      MODE_BITS:  if (take) inc = IW'(flips[0]) + IW'(flips[1]);
      MODE_WORD:  if (take) inc = IW'(|bad);
      MODE_BYTES: if (take) inc = IW'(bad[0]) + IW'(bad[1]);
      default:    inc = '0;
    endcase
  end

  AST_OOF_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OOF) |-> (inc == IW'(oof))) else $error("oof increment"); // R2
  AST_BITS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BITS) |-> (inc <= IW'(2 * BYTE_W))) else $error("bit cap"); // R3
  AST_WORD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WORD) |-> (inc <= IW'(1))) else $error("word cap"); // R4
  AST_BYTES_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYTES) |-> (inc <= IW'(2))) else $error("byte cap"); // R5
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_OOF && !take) |-> (inc == '0)) else $error("gate"); // R6
endmodule

// File: rtl/fec_accum.sv
module fec_accum #(
  parameter int CNT_W = 16,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] held_q
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] next_cnt;

  assign sum      = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
  assign next_cnt = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else if (clr) begin
      held_q <= cnt_q;
      cnt_q  <= CNT_W'(inc);
    end else begin
      cnt_q  <= next_cnt;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == MAXV) |=> (cnt_q == MAXV)) else $error("wrap"); // R7
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q))) else $error("decrease"); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (held_q == $past(cnt_q))) else $error("snap hold"); // R8
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == CNT_W'($past(inc)))) else $error("snap keep"); // R8
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(held_q)) else $error("held moved"); // R8
endmodule

// File: rtl/frame_err_counter.sv
module frame_err_counter
  import fec_pkg::*;
#(
  parameter int   BYTE_W = 8,
  parameter int   CNT_W  = 16,
  parameter logic [BYTE_W-1:0] EXP1 = 8'hF6,
  parameter logic [BYTE_W-1:0] EXP2 = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fa_valid,
  output logic              fa_ready,
  input  logic [BYTE_W-1:0] fa1_i,
  input  logic [BYTE_W-1:0] fa2_i,
  input  logic              in_frame,
  input  logic              oof_pulse,
  input  logic [1:0]        mode,
  input  logic              snap,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  held_count
);
  localparam int IW = $clog2(2 * BYTE_W + 1);

  fec_mode_e   mode_e;
  logic        take;
  logic [IW-1:0] inc;

  assign fa_ready = 1'b1;
  assign mode_e   = fec_mode_e'(mode);
  assign take     = fa_valid && fa_ready && in_frame;

  fec_increment #(.BYTE_W(BYTE_W), .EXP1(EXP1), .EXP2(EXP2), .IW(IW)) i_inc (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .take(take),
    .fa1(fa1_i), .fa2(fa2_i), .oof(oof_pulse), .inc(inc)
  );

  fec_accum #(.CNT_W(CNT_W), .IW(IW)) i_acc (
    .clk(clk), .rst_n(rst_n), .inc(inc), .clr(snap),
    .cnt_q(err_count), .held_q(held_count)
  );
endmodule

// File: tb/test_frame_err_counter.sv
module test_frame_err_counter;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] a;
    logic [7:0] b;
    logic       inf;
    logic       v;
    logic       oof;
    logic [4:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{2'b00, 8'hF6, 8'h28, 1'b1, 1'b1, 1'b1, 5'd1,  4'd2}, // R2
    '{2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 5'd1,  4'd2}, // R2 bytes ignored
    '{2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 5'd0,  4'd2}, // R2
    '{2'b01, 8'hF6, 8'h28, 1'b1, 1'b1, 1'b0, 5'd0,  4'd3}, // R3 clean word
    '{2'b01, 8'hF7, 8'h28, 1'b1, 1'b1, 1'b0, 5'd1,  4'd3}, // R3 one bit
    '{2'b01, 8'h09, 8'hD7, 1'b1, 1'b1, 1'b0, 5'd16, 4'd3}, // R3 all bits
    '{2'b01, 8'hF6, 8'h29, 1'b1, 1'b1, 1'b1, 5'd1,  4'd6}, // R6 oof ignored
    '{2'b10, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 5'd1,  4'd4}, // R4
    '{2'b10, 8'hF6, 8'h20, 1'b1, 1'b1, 1'b0, 5'd1,  4'd4}, // R4
    '{2'b10, 8'hF6, 8'h28, 1'b1, 1'b1, 1'b1, 5'd0,  4'd4}, // R4
    '{2'b11, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 5'd2,  4'd5}, // R5
    '{2'b11, 8'hF0, 8'h28, 1'b1, 1'b1, 1'b0, 5'd1,  4'd5}, // R5
    '{2'b11, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6}, // R6 out of frame
    '{2'b01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 5'd0,  4'd6}, // R6 no strobe
    '{2'b01, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6}, // R6
    '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 5'd1,  4'd2}  // R2 out of frame
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fa_valid, fa_ready, in_frame, oof_pulse, snap;
  logic [7:0]  fa1_i, fa2_i;
  logic [1:0]  mode;
  logic [15:0] err_count, held_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_err_counter i_frame_err_counter (
    .clk(clk), .rst_n(rst_n), .fa_valid(fa_valid), .fa_ready(fa_ready),
    .fa1_i(fa1_i), .fa2_i(fa2_i), .in_frame(in_frame), .oof_pulse(oof_pulse),
    .mode(mode), .snap(snap), .err_count(err_count), .held_count(held_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fa_valid = 1'b0; oof_pulse = 1'b0; snap = 1'b0; in_frame = 1'b1;
    fa1_i = 8'hF6; fa2_i = 8'h28; mode = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int run;
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R1 count in reset", 32'(err_count), 0);
    check("R1 held in reset", 32'(held_count), 0);
    check("R9 ready in reset", 32'(fa_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", 32'(err_count), 0);
    check("R1 held after reset", 32'(held_count), 0);

    run = 0;
    for (int i = 0; i < 16; i++) begin
      mode = VECS[i].m; fa1_i = VECS[i].a; fa2_i = VECS[i].b;
      in_frame = VECS[i].inf; fa_valid = VECS[i].v; oof_pulse = VECS[i].oof;
      @(negedge clk);
      run += int'(VECS[i].exp);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(err_count), 32'(run));
      check("R9 ready", 32'(fa_ready), 1);
    end
    idle();
    @(negedge clk);
    check("R6 idle keeps count", 32'(err_count), 32'(run));

    // R8: snapshot with an increment in the same cycle
    snap = 1'b1; mode = 2'b11; fa1_i = 8'h00; fa2_i = 8'h00; fa_valid = 1'b1;
    @(negedge clk);
    check("R8 held gets old count", 32'(held_count), 32'(run));
    check("R8 increment kept", 32'(err_count), 2);
    idle();
    @(negedge clk);
    check("R8 held stable", 32'(held_count), 32'(run));
    snap = 1'b1;
    @(negedge clk);
    idle();
    check("R8 second snapshot", 32'(held_count), 2);
    check("R8 live cleared", 32'(err_count), 0);

    // R7: saturation after 4096 frames of 16 bit errors
    mode = 2'b01; fa1_i = 8'h09; fa2_i = 8'hD7; fa_valid = 1'b1;
    repeat (4095) @(negedge clk);
    check("R7 below ceiling", 32'(err_count), 65520);
    @(negedge clk);
    check("R7 saturated", 32'(err_count), 32'hFFFF);
    @(negedge clk);
    check("R7 no wrap", 32'(err_count), 32'hFFFF);
    mode = 2'b10;
    @(negedge clk);
    check("R7 held at max", 32'(err_count), 32'hFFFF);
    idle();
    snap = 1'b1;
    @(negedge clk);
    idle();
    check("R8 saturated snapshot", 32'(held_count), 32'hFFFF);
    check("R8 cleared after saturation", 32'(err_count), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule